// File: doc/BRIEF.md
# Time-of-Day Snapshot Register Front End

This block sits between a simple 32-bit register bus and a free-running time-of-day counter core. The core keeps 48 bits of seconds and 32 bits of nanoseconds, so the full time does not fit in one bus word. Software therefore has to read it and set it as three separate words.

On the read side, reading the nanoseconds word freezes the live seconds value at the same instant. The two seconds words that software reads afterwards come from that frozen copy, so the three words always describe one moment, even while the counter keeps running.

On the write side, the two seconds words are first held in shadow registers. Writing the nanoseconds word then hands the counter core a one-cycle load strobe, together with the complete 80-bit value, in a single cycle. A fixed read-only word reports the counter clock frequency in Hz.

Top module: `tod_snap_regs`

## Requirements
- R1: After reset, bus_rdata, load_stb, load_sec and load_ns are zero. The frozen seconds copy and both shadow words are also zero, so reading a seconds word before any nanoseconds read returns 0.
- R2: A read (bus_rd high) at offset 0x108 returns the live nanoseconds value present at that clock edge. It appears zero-extended on bus_rdata from the following cycle.
- R3: A read at offset 0x108 also freezes live_sec. Later reads at 0x104 return the frozen bits 31:0. Later reads at 0x100 return the frozen bits 47:32 in bus_rdata bits 15:0, with bits 31:16 zero.
- R4: Only a read at 0x108 updates the frozen copy. Reading the seconds words and changes on live_sec leave it unchanged.
- R5: A read at offset 0x038 returns the counter clock frequency parameter, 200000000 by default. Writes to that offset have no effect on any read or load output.
- R6: A write at 0x100 stores bus_wdata bits 15:0 as shadow seconds bits 47:32, and bits 31:16 are ignored. A write at 0x104 stores shadow bits 31:0. Neither write raises load_stb or changes load_sec or load_ns.
- R7: A write at 0x108 raises load_stb in the following cycle only. In that same cycle load_sec equals the shadow seconds and load_ns equals the written data.
- R8: load_sec and load_ns hold their values between commits. The shadow words survive a commit, so a second nanoseconds write reuses them.
- R9: Reads at any other offset return 0, and writes to any other offset have no effect.
- R10: bus_rdata changes only in the cycle after a read. Otherwise it keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wr | input | 1 | Write enable for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read enable for one cycle |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| live_sec | input | 48 | Running seconds from the counter core |
| live_ns | input | 32 | Running nanoseconds from the counter core |
| load_stb | output | 1 | One-cycle strobe that loads a new time into the core |
| load_sec | output | 48 | Seconds value to load |
| load_ns | output | 32 | Nanoseconds value to load |

## Verification
The bench changes the live time on every operation, so any design that reads a seconds word straight from live_sec instead of the frozen copy returns the wrong value. It writes ones into bits 31:16 of the high seconds word; a design that keeps them would show them on load_sec. It also sends writes to the seconds words and to the frequency offset and checks that load_stb stays low, which catches a commit fired by the wrong word. Back-to-back nanoseconds writes check that the shadow survives a commit. Idle cycles between reads check that the read data holds.

// File: rtl/tod_snap_pkg.sv
package tod_snap_pkg;

   // One select bit per mapped register word
   typedef struct packed {
      logic sec_hi;
      logic sec_lo;
      logic nsec;
      logic freq;
   } tod_sel_t;

   localparam tod_sel_t SEL_NONE = '{sec_hi: 1'b0, sec_lo: 1'b0, nsec: 1'b0, freq: 1'b0};

   function automatic tod_sel_t sel_gate(input tod_sel_t s, input logic en);
      tod_sel_t r;
      r.sec_hi = s.sec_hi & en;
      r.sec_lo = s.sec_lo & en;
      r.nsec   = s.nsec   & en;
      r.freq   = s.freq   & en;
      return r;
   endfunction

endpackage

// File: rtl/tod_snap_decode.sv
module tod_snap_decode
   import tod_snap_pkg::*;
#(
   parameter int                ADDR_W     = 12,
   parameter logic [ADDR_W-1:0] OFF_SEC_HI = 12'h100,
   parameter logic [ADDR_W-1:0] OFF_SEC_LO = 12'h104,
   parameter logic [ADDR_W-1:0] OFF_NSEC   = 12'h108,
   parameter logic [ADDR_W-1:0] OFF_FREQ   = 12'h038
) (
   input  logic [ADDR_W-1:0] addr,
   output tod_sel_t          sel
);

   always_comb begin
      sel        = SEL_NONE;
      sel.sec_hi = (addr == OFF_SEC_HI);
      sel.sec_lo = (addr == OFF_SEC_LO);
      sel.nsec   = (addr == OFF_NSEC);
      sel.freq   = (addr == OFF_FREQ);
   end

endmodule

// File: rtl/tod_snap_capture.sv
module tod_snap_capture #(
   parameter int SEC_W = 48
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_en,
   input  logic [SEC_W-1:0] live_sec,
   output logic [SEC_W-1:0] snap_sec
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap_sec <= '0;
      end else if (cap_en) begin
         snap_sec <= live_sec;
      end
   end

endmodule

// File: rtl/tod_snap_stage.sv
module tod_snap_stage #(
   parameter int DATA_W = 32,
   parameter int SEC_W  = 48,
   parameter int NS_W   = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hi,
   input  logic              wr_lo,
   input  logic              wr_ns,
   input  logic [DATA_W-1:0] wdata,
   output logic              load_stb,
   output logic [SEC_W-1:0]  load_sec,
   output logic [NS_W-1:0]   load_ns
);

   localparam int HI_W = SEC_W - DATA_W;

   logic [HI_W-1:0]   shadow_hi;
   logic [DATA_W-1:0] shadow_lo;

   // Shadow words: generate one register per seconds word
   for (genvar w = 0; w < 2; w++) begin : g_word
      if (w == 0) begin : g_lo
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     shadow_lo <= '0;
            else if (wr_lo) shadow_lo <= wdata;
         end
      end else begin : g_hi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     shadow_hi <= '0;
            else if (wr_hi) shadow_hi <= wdata[HI_W-1:0];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         load_stb <= 1'b0;
         load_sec <= '0;
         load_ns  <= '0;
      end else begin
         load_stb <= wr_ns;
         if (wr_ns) begin
            load_sec <= {shadow_hi, shadow_lo};
            load_ns  <= wdata[NS_W-1:0];
         end
      end
   end

endmodule

// File: rtl/tod_snap_rmux.sv
module tod_snap_rmux
   import tod_snap_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int SEC_W  = 48,
   parameter int NS_W   = 32,
   parameter int CLK_HZ = 200_000_000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  tod_sel_t          rd_sel,
   input  logic              rd_en,
   input  logic [NS_W-1:0]   live_ns,
   input  logic [SEC_W-1:0]  snap_sec,
   output logic [DATA_W-1:0] rdata
);

   localparam logic [DATA_W-1:0] FREQ_WORD = DATA_W'(CLK_HZ);

   logic [DATA_W-1:0] ns_word;
   logic [DATA_W-1:0] hi_word;
   logic [DATA_W-1:0] lo_word;
   logic [DATA_W-1:0] rd_next;

   // Zero-extend narrow fields; variant chosen by width
   if (NS_W == DATA_W) begin : g_ns_full
      assign ns_word = live_ns;
   end else begin : g_ns_pad
      assign ns_word = {{(DATA_W-NS_W){1'b0}}, live_ns};
   end

   if (SEC_W == 2*DATA_W) begin : g_hi_full
      assign hi_word = snap_sec[SEC_W-1:DATA_W];
   end else begin : g_hi_pad
      assign hi_word = {{(2*DATA_W-SEC_W){1'b0}}, snap_sec[SEC_W-1:DATA_W]};
   end

   assign lo_word = snap_sec[DATA_W-1:0];

   always_comb begin
      rd_next = '0;
      unique case (1'b1)
         rd_sel.nsec:   rd_next = ns_word;
         rd_sel.sec_lo: rd_next = lo_word;
         rd_sel.sec_hi: rd_next = hi_word;
         rd_sel.freq:   rd_next = FREQ_WORD;
         default:       rd_next = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rd_next;
   end

endmodule

// File: rtl/tod_snap_regs.sv
module tod_snap_regs
   import tod_snap_pkg::*;
#(
   parameter int                ADDR_W     = 12,
   parameter int                DATA_W     = 32,
   parameter int                SEC_W      = 48,
   parameter int                NS_W       = 32,
   parameter int                CLK_HZ     = 200_000_000,
   parameter logic [ADDR_W-1:0] OFF_SEC_HI = 12'h100,
   parameter logic [ADDR_W-1:0] OFF_SEC_LO = 12'h104,
   parameter logic [ADDR_W-1:0] OFF_NSEC   = 12'h108,
   parameter logic [ADDR_W-1:0] OFF_FREQ   = 12'h038
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_rd,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [SEC_W-1:0]  live_sec,
   input  logic [NS_W-1:0]   live_ns,
   output logic              load_stb,
   output logic [SEC_W-1:0]  load_sec,
   output logic [NS_W-1:0]   load_ns
);

   // Elaboration-time parameter checks
   if (SEC_W <= DATA_W || SEC_W > 2*DATA_W) begin : g_bad_sec_w
      $error("SEC_W must span exactly two data words");
   end
   if (NS_W > DATA_W || NS_W < 1) begin : g_bad_ns_w
      $error("NS_W must fit in one data word");
   end
   if (CLK_HZ < 1) begin : g_bad_clk
      $error("CLK_HZ must be positive");
   end

   tod_sel_t         sel;
   tod_sel_t         rd_sel;
   tod_sel_t         wr_sel;
   logic [SEC_W-1:0] snap_sec;

   tod_snap_decode #(
      .ADDR_W    (ADDR_W),
      .OFF_SEC_HI(OFF_SEC_HI),
      .OFF_SEC_LO(OFF_SEC_LO),
      .OFF_NSEC  (OFF_NSEC),
      .OFF_FREQ  (OFF_FREQ)
   ) u_decode (
      .addr(bus_addr),
      .sel (sel)
   );

   assign rd_sel = sel_gate(sel, bus_rd);
   assign wr_sel = sel_gate(sel, bus_wr);

   tod_snap_capture #(
      .SEC_W(SEC_W)
   ) u_capture (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap_en  (rd_sel.nsec),
      .live_sec(live_sec),
      .snap_sec(snap_sec)
   );

   tod_snap_stage #(
      .DATA_W(DATA_W),
      .SEC_W (SEC_W),
      .NS_W  (NS_W)
   ) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_hi   (wr_sel.sec_hi),
      .wr_lo   (wr_sel.sec_lo),
      .wr_ns   (wr_sel.nsec),
      .wdata   (bus_wdata),
      .load_stb(load_stb),
      .load_sec(load_sec),
      .load_ns (load_ns)
   );

   tod_snap_rmux #(
      .DATA_W(DATA_W),
      .SEC_W (SEC_W),
      .NS_W  (NS_W),
      .CLK_HZ(CLK_HZ)
   ) u_rmux (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_sel  (rd_sel),
      .rd_en   (bus_rd),
      .live_ns (live_ns),
      .snap_sec(snap_sec),
      .rdata   (bus_rdata)
   );

endmodule

// File: rtl/tod_snap_regs_chk.sv
module tod_snap_regs_chk #(
   parameter int                ADDR_W     = 12,
   parameter int                DATA_W     = 32,
   parameter int                SEC_W      = 48,
   parameter int                NS_W       = 32,
   parameter int                CLK_HZ     = 200_000_000,
   parameter logic [ADDR_W-1:0] OFF_SEC_HI = 12'h100,
   parameter logic [ADDR_W-1:0] OFF_SEC_LO = 12'h104,
   parameter logic [ADDR_W-1:0] OFF_NSEC   = 12'h108,
   parameter logic [ADDR_W-1:0] OFF_FREQ   = 12'h038
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              bus_rd,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [SEC_W-1:0]  live_sec,
   input logic [NS_W-1:0]   live_ns,
   input logic              load_stb,
   input logic [SEC_W-1:0]  load_sec,
   input logic [NS_W-1:0]   load_ns
);

   logic wr_ns_c;
   logic wr_sec_c;
   assign wr_ns_c  = bus_wr && (bus_addr == OFF_NSEC);
   assign wr_sec_c = bus_wr && ((bus_addr == OFF_SEC_HI) || (bus_addr == OFF_SEC_LO));

   AST_NS_READ_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == OFF_NSEC) |=> bus_rdata == DATA_W'($past(live_ns))); // R2

   AST_HI_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == OFF_SEC_HI) |=> bus_rdata[DATA_W-1:SEC_W-DATA_W] == '0); // R3

   AST_FREQ_CONST: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == OFF_FREQ) |=> bus_rdata == DATA_W'(CLK_HZ)); // R5

   AST_SEC_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
      wr_sec_c |=> !load_stb); // R6

   AST_COMMIT_STB: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ns_c |=> load_stb); // R7

   AST_COMMIT_NS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ns_c |=> load_ns == $past(bus_wdata[NS_W-1:0])); // R7

   AST_STB_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_ns_c |=> !load_stb); // R7

   AST_LOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_ns_c |=> ($stable(load_sec) && $stable(load_ns))); // R8

   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata)); // R10

endmodule

bind tod_snap_regs tod_snap_regs_chk #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .SEC_W     (SEC_W),
   .NS_W      (NS_W),
   .CLK_HZ    (CLK_HZ),
   .OFF_SEC_HI(OFF_SEC_HI),
   .OFF_SEC_LO(OFF_SEC_LO),
   .OFF_NSEC  (OFF_NSEC),
   .OFF_FREQ  (OFF_FREQ)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_addr (bus_addr),
   .bus_wr   (bus_wr),
   .bus_wdata(bus_wdata),
   .bus_rd   (bus_rd),
   .bus_rdata(bus_rdata),
   .live_sec (live_sec),
   .live_ns  (live_ns),
   .load_stb (load_stb),
   .load_sec (load_sec),
   .load_ns  (load_ns)
);

// File: tb/tod_snap_regs_tb.sv
module tod_snap_regs_tb;

   localparam logic [11:0] A_HI   = 12'h100;
   localparam logic [11:0] A_LO   = 12'h104;
   localparam logic [11:0] A_NS   = 12'h108;
   localparam logic [11:0] A_FREQ = 12'h038;
   localparam logic [31:0] FREQ_V = 32'd200_000_000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_rdata;
   logic [47:0] live_sec = '0;
   logic [31:0] live_ns = '0;
   logic        load_stb;
   logic [47:0] load_sec;
   logic [31:0] load_ns;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // Reference model state
   logic [15:0] m_hi = '0;
   logic [31:0] m_lo = '0;
   logic [47:0] m_snap = '0;
   logic [47:0] m_lsec = '0;
   logic [31:0] m_lns = '0;
   logic [31:0] m_rdata = '0;

   always #2.5 clk = ~clk;

   tod_snap_regs u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_addr (bus_addr),
      .bus_wr   (bus_wr),
      .bus_wdata(bus_wdata),
      .bus_rd   (bus_rd),
      .bus_rdata(bus_rdata),
      .live_sec (live_sec),
      .live_ns  (live_ns),
      .load_stb (load_stb),
      .load_sec (load_sec),
      .load_ns  (load_ns)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Expected read value, updating the model snapshot
   function automatic logic [31:0] exp_read(input logic [11:0] a);
      if (a == A_NS) begin
         m_snap = live_sec;
         return live_ns;
      end else if (a == A_LO) return m_snap[31:0];
      else if (a == A_HI) return {16'h0, m_snap[47:32]};
      else if (a == A_FREQ) return FREQ_V;
      return 32'h0;
   endfunction

   function automatic string req_of(input logic [11:0] a);
      if (a == A_NS) return "R2";
      if (a == A_LO || a == A_HI) return "R3";
      if (a == A_FREQ) return "R5";
      return "R9";
   endfunction

   task automatic do_read(input logic [11:0] a);
      logic [31:0] e;
      bus_addr = a;
      bus_rd   = 1'b1;
      e = exp_read(a);
      @(negedge clk);
      bus_rd = 1'b0;
      m_rdata = e;
      check(req_of(a), {32'h0, bus_rdata}, {32'h0, e});
      check("R6", {63'h0, load_stb}, 64'h0);
   endtask

   task automatic do_write(input logic [11:0] a, input logic [31:0] d);
      logic stb_e;
      bus_addr  = a;
      bus_wr    = 1'b1;
      bus_wdata = d;
      stb_e = 1'b0;
      if (a == A_HI) m_hi = d[15:0];
      else if (a == A_LO) m_lo = d;
      else if (a == A_NS) begin
         m_lsec = {m_hi, m_lo};
         m_lns  = d;
         stb_e  = 1'b1;
      end
      @(negedge clk);
      bus_wr = 1'b0;
      check("R7", {63'h0, load_stb}, {63'h0, stb_e});
      check("R8", {16'h0, load_sec}, {16'h0, m_lsec});
      check("R7", {32'h0, load_ns}, {32'h0, m_lns});
      check("R10", {32'h0, bus_rdata}, {32'h0, m_rdata});
   endtask

   task automatic new_live();
      live_ns  = $urandom % 1_000_000_000;
      live_sec = {16'($urandom), 32'($urandom)};
   endtask

   function automatic logic [11:0] pick_addr();
      case ($urandom % 6)
         0: return A_HI;
         1: return A_LO;
         2, 3: return A_NS;
         4: return A_FREQ;
         default: return 12'h10C;
      endcase
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      live_sec = 48'hABCD_1234_5678;
      live_ns  = 32'd999_999_999;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state, seconds read before any nanoseconds read is zero
      check("R1", {32'h0, bus_rdata}, 64'h0);
      check("R1", {63'h0, load_stb}, 64'h0);
      check("R1", {16'h0, load_sec}, 64'h0);
      check("R1", {32'h0, load_ns}, 64'h0);
      do_read(A_LO);
      do_read(A_HI);

      // R3/R4: snapshot stays while live time moves
      do_read(A_NS);
      new_live();
      do_read(A_LO);
      new_live();
      do_read(A_HI);
      do_read(A_LO);

      // R10: idle cycles keep read data
      repeat (3) @(negedge clk);
      check("R10", {32'h0, bus_rdata}, {32'h0, m_rdata});

      // R6: upper bits of seconds-high ignored; no commit from seconds words
      do_write(A_HI, 32'hFFFF_0042);
      do_write(A_LO, 32'h1111_2222);
      check("R6", {16'h0, load_sec}, 64'h0);
      do_write(A_NS, 32'd123);
      check("R6", {16'h0, load_sec}, 64'h0042_1111_2222);

      // R8: back-to-back commits reuse shadow
      do_write(A_NS, 32'd456);
      do_write(A_NS, 32'd789);
      check("R8", {16'h0, load_sec}, 64'h0042_1111_2222);

      // R5/R9: writes to frequency and unmapped offsets ignored
      do_write(A_FREQ, 32'h0);
      do_write(12'h200, 32'hDEAD_BEEF);
      do_read(A_FREQ);
      do_read(12'h200);
      do_write(A_NS, 32'd5);
      check("R9", {16'h0, load_sec}, 64'h0042_1111_2222);

      // Random mix
      for (int i = 0; i < 400; i++) begin
         logic [11:0] a;
         new_live();
         a = pick_addr();
         if ($urandom % 2) do_read(a);
         else do_write(a, $urandom);
         if ($urandom % 4 == 0) begin
            @(negedge clk);
            check("R10", {32'h0, bus_rdata}, {32'h0, m_rdata});
            check("R7", {63'h0, load_stb}, 64'h0);
         end
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule